// File: doc/BRIEF.md
# Local Bus Cycle Sequencer

This block runs one local bus transfer at a time on behalf of a processor core. The core presents a cycle kind and write data with a valid flag. The block takes the request when the bus is idle and drives a 3-bit status code to the bus for the whole transfer. It ends the transfer when the bus reports ready, then gives the core a one-clock completion pulse and, for read-type cycles, the captured read data.

Two ready inputs decide when a transfer ends. The synchronous ready is used directly at the rising clock edge. The asynchronous ready first goes through a falling-edge capture stage, so it must arrive half a clock earlier to end the same cycle. The core can also mark an instruction as locked. The block then drives an active-low lock output from the first data cycle of that instruction until the instruction is over. While the lock output is low, the block refuses instruction fetch requests.

Top module: `bus_cycle_ctrl`

## Requirements
- R1: The status code for each cycle kind is: interrupt acknowledge 000, I/O read 001, I/O write 010, halt 011, instruction fetch 100, memory read 101, memory write 110. Bit 2 separates memory (1) from I/O (0). Bit 1 is high for the write cycles 010 and 110.
- R2: After reset and between transfers the status is 111 (passive). A request whose kind is 111 is never accepted. `reqAck` is high only while the status is passive.
- R3: An accepted request drives its code from the next clock. The code is held for one address clock and then for every wait clock until the transfer ends. Ready is ignored during the address clock.
- R4: If `syncRdy` is high during the first clock after the address clock, the transfer ends at the rising edge that closes that clock (zero wait states). Holding `syncRdy` high always ends a transfer that way.
- R5: `asyncRdy` counts only after it is captured on a falling clock edge. A level present before the falling edge inside a clock ends the transfer at the next rising edge. A level that arrives after the falling edge costs one more wait state.
- R6: While both ready inputs are low, the code is held and wait states are added without limit.
- R7: When a transfer ends, `done` is high for exactly one clock and the status returns to 111. For kinds 000, 001, 100 and 101, `rdData` takes the `busRdata` value present at the ending edge. Other kinds leave `rdData` unchanged.
- R8: `busWrEn` is high, with `busWdata` equal to the request's write data, exactly while a 010 or 110 cycle is on the bus.
- R9: With `lockPrefix` high, `lockN` goes low in the same clock that a non-fetch cycle first shows its code. It stays low until the bus is idle with `lockPrefix` low, and rises one clock after that.
- R10: While `lockN` is low, an instruction fetch request is not accepted. Data cycle requests are still accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Core presents a cycle request |
| reqKind | input | 3 | Requested cycle kind, in the status encoding |
| reqWdata | input | DATA_W | Write data for write cycles |
| lockPrefix | input | 1 | Current instruction is locked |
| reqAck | output | 1 | Request taken at this clock edge |
| done | output | 1 | One-clock pulse at the end of a transfer |
| rdData | output | DATA_W | Data captured by the last read-type transfer |
| syncRdy | input | 1 | Ready, used at the rising edge |
| asyncRdy | input | 1 | Ready, captured on the falling edge first |
| busRdata | input | DATA_W | Read data from the bus |
| busStatus | output | 3 | Bus cycle status code |
| busWdata | output | DATA_W | Write data driven to the bus |
| busWrEn | output | 1 | Write data valid on the bus |
| lockN | output | 1 | Active-low bus lock |

## Verification
Two things can fall in the same clock. A fetch request can meet a live lock, and the release of the lock can meet the next acceptance decision. The bench holds a fetch request pending while a locked data sequence finishes. It then drops `lockPrefix` with the bus idle and checks three things: the fetch is still refused at the edge that clears the lock, `lockN` is high after that edge, and the fetch is taken one clock later. A second collision is an asynchronous ready that arrives just after the falling edge while a synchronous-path transfer would have ended. The bench judges it by checking that the code is still held one clock later and that `done` comes one clock later.

// File: rtl/bcc_pkg.sv
package bcc_pkg;
  localparam logic [2:0] CODE_INTA    = 3'b000;
  localparam logic [2:0] CODE_IORD    = 3'b001;
  localparam logic [2:0] CODE_IOWR    = 3'b010;
  localparam logic [2:0] CODE_HALT    = 3'b011;
  localparam logic [2:0] CODE_FETCH   = 3'b100;
  localparam logic [2:0] CODE_MEMRD   = 3'b101;
  localparam logic [2:0] CODE_MEMWR   = 3'b110;
  localparam logic [2:0] CODE_PASSIVE = 3'b111;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_WAIT = 2'd2
  } bccState_t;

  typedef struct packed {
    logic start;
    logic finish;
  } bccStrobe_t;
endpackage

// File: rtl/bcc_ctrl.sv
module bcc_ctrl
  import bcc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [2:0] reqKind,
  input  logic       lockPrefix,
  input  logic       rdyNow,
  output logic       reqAck,
  output logic       done,
  output logic       lockN,
  output bccStrobe_t strb
);
  bccState_t state;
  logic lockOn;
  logic fetchReq;
  logic kindOk;
  logic startNow;
  logic finishNow;

  assign fetchReq  = (reqKind == CODE_FETCH);
  assign kindOk    = (reqKind != CODE_PASSIVE);
  assign startNow  = (state == ST_IDLE) && reqValid && kindOk && !(lockOn && fetchReq);
  assign finishNow = (state == ST_WAIT) && rdyNow;

  assign strb.start  = startNow;
  assign strb.finish = finishNow;
  assign reqAck      = startNow;
  assign lockN       = !lockOn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      done   <= 1'b0;
      lockOn <= 1'b0;
    end else begin
      done <= finishNow;
      case (state)
        ST_IDLE: if (startNow) state <= ST_ADDR;
        ST_ADDR: state <= ST_WAIT;
        ST_WAIT: if (rdyNow) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
      if (startNow && lockPrefix && !fetchReq)
        lockOn <= 1'b1;
      else if ((state == ST_IDLE) && !lockPrefix)
        lockOn <= 1'b0;
    end
  end

  // R3: the address clock is always followed by a wait-state clock
  p_addr_then_wait_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ADDR) |=> (state == ST_WAIT));

  // R6: with no ready the transfer stays in the wait state
  p_wait_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_WAIT) && !rdyNow) |=> (state == ST_WAIT));

  // R7: the completion pulse lasts one clock
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
endmodule

// File: rtl/bcc_dp.sv
module bcc_dp
  import bcc_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  bccStrobe_t        strb,
  input  logic [2:0]        reqKind,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              syncRdy,
  input  logic              asyncRdy,
  input  logic [DATA_W-1:0] busRdata,
  output logic              rdyNow,
  output logic [2:0]        busStatus,
  output logic [DATA_W-1:0] busWdata,
  output logic              busWrEn,
  output logic [DATA_W-1:0] rdData
);
  logic [2:0]        statusReg;
  logic [DATA_W-1:0] wdataReg;
  logic [DATA_W-1:0] rdReg;
  logic              asyncSeen;
  logic              readKind;

  // capture on the falling edge: half a clock of synchronizing delay
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) asyncSeen <= 1'b0;
    else       asyncSeen <= asyncRdy;
  end

  assign rdyNow   = syncRdy || asyncSeen;
  assign readKind = !statusReg[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusReg <= CODE_PASSIVE;
      wdataReg  <= '0;
      rdReg     <= '0;
    end else begin
      if (strb.start) begin
        statusReg <= reqKind;
        wdataReg  <= reqWdata;
      end else if (strb.finish) begin
        statusReg <= CODE_PASSIVE;
        if (readKind) rdReg <= busRdata;
      end
    end
  end

  assign busStatus = statusReg;
  assign busWdata  = wdataReg;
  assign busWrEn   = (statusReg == CODE_IOWR) || (statusReg == CODE_MEMWR);
  assign rdData    = rdReg;

  // R7: read data moves only at the edge that ends a transfer
  p_rd_stable_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strb.finish |=> $stable(rdData));

  // R3: a driven code is held until the transfer ends
  p_code_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    ((statusReg != CODE_PASSIVE) && !strb.finish) |=> $stable(statusReg));
endmodule

// File: rtl/bus_cycle_ctrl.sv
module bus_cycle_ctrl
  import bcc_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [2:0]        reqKind,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              lockPrefix,
  output logic              reqAck,
  output logic              done,
  output logic [DATA_W-1:0] rdData,
  input  logic              syncRdy,
  input  logic              asyncRdy,
  input  logic [DATA_W-1:0] busRdata,
  output logic [2:0]        busStatus,
  output logic [DATA_W-1:0] busWdata,
  output logic              busWrEn,
  output logic              lockN
);
  bccStrobe_t strb;
  logic       rdyNow;

  bcc_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqKind    (reqKind),
    .lockPrefix (lockPrefix),
    .rdyNow     (rdyNow),
    .reqAck     (reqAck),
    .done       (done),
    .lockN      (lockN),
    .strb       (strb)
  );

  bcc_dp #(.DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .reqKind   (reqKind),
    .reqWdata  (reqWdata),
    .syncRdy   (syncRdy),
    .asyncRdy  (asyncRdy),
    .busRdata  (busRdata),
    .rdyNow    (rdyNow),
    .busStatus (busStatus),
    .busWdata  (busWdata),
    .busWrEn   (busWrEn),
    .rdData    (rdData)
  );

  // R2: the block is passive whenever it completes or accepts
  p_passive_at_done_r2: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (busStatus == CODE_PASSIVE));
  p_ack_when_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqAck |-> (busStatus == CODE_PASSIVE));

  // R10: no fetch on the bus while locked
  p_no_fetch_locked_r10: assert property (@(posedge clk) disable iff (!rstN)
    !lockN |-> (busStatus != CODE_FETCH));
endmodule

// File: tb/bus_cycle_ctrl_bench.sv
module bus_cycle_ctrl_bench;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic [2:0]    reqKind = 3'b111;
  logic [DW-1:0] reqWdata = '0;
  logic          lockPrefix = 1'b0;
  logic          reqAck, done, busWrEn, lockN;
  logic [DW-1:0] rdData, busWdata;
  logic          syncRdy = 1'b0;
  logic          asyncRdy = 1'b0;
  logic [DW-1:0] busRdata = '0;
  logic [2:0]    busStatus;

  int nRun = 0;
  int nFail = 0;
  logic [DW-1:0] lastRd = '0;

  always #10 clk = ~clk;

  bus_cycle_ctrl #(.DATA_W(DW)) u_bus_cycle_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .reqWdata(reqWdata), .lockPrefix(lockPrefix), .reqAck(reqAck),
    .done(done), .rdData(rdData), .syncRdy(syncRdy), .asyncRdy(asyncRdy),
    .busRdata(busRdata), .busStatus(busStatus), .busWdata(busWdata),
    .busWrEn(busWrEn), .lockN(lockN)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // step to a point just after a rising edge
  task automatic tick();
    @(posedge clk); #1;
  endtask

  // one transfer: waits = clocks of ready low after the address clock
  task automatic doCycle(input logic [2:0] kind, input logic [DW-1:0] wd,
                         input logic [DW-1:0] rd, input bit useAsync,
                         input int waits);
    bit isRd = !kind[1];
    bit isWr = (kind == 3'b010) || (kind == 3'b110);
    tick();
    reqValid = 1; reqKind = kind; reqWdata = wd; busRdata = rd;
    syncRdy = 0; asyncRdy = 0;
    #3;
    chk(reqAck == 1, "R2", "ack when idle", reqAck, 1);
    tick();
    reqValid = 0; reqKind = 3'b111;
    #3;
    chk(busStatus == kind, "R1", "status code", busStatus, kind);
    chk(busWrEn == isWr, "R8", "write enable", busWrEn, isWr);
    if (isWr) chk(busWdata == wd, "R8", "write data", busWdata, wd);
    for (int i = 0; i < waits; i++) begin
      tick(); #3;
      chk(busStatus == kind && !done, "R6", "held in wait", busStatus, kind);
    end
    tick();
    if (useAsync) asyncRdy = 1; else syncRdy = 1;
    tick();
    syncRdy = 0; asyncRdy = 0;
    #3;
    chk(done == 1, useAsync ? "R5" : "R4", "done after ready", done, 1);
    chk(busStatus == 3'b111, "R7", "passive after end", busStatus, 7);
    if (isRd) lastRd = rd;
    chk(rdData == lastRd, "R7", "read data", rdData, lastRd);
    tick(); #3;
    chk(done == 0, "R7", "done one clock", done, 0);
  endtask

  task automatic testReset();
    #3;
    chk(busStatus == 3'b111, "R2", "reset status", busStatus, 7);
    chk(lockN == 1 && done == 0, "R9", "reset lock/done", lockN, 1);
  endtask

  task automatic testAllKinds();
    for (int k = 0; k < 7; k++)
      doCycle(3'(k), 16'h1100 + 16'(k), 16'hA000 + 16'(k), k[0], 0);
  endtask

  task automatic testWaits();
    doCycle(3'b101, 16'h0, 16'h1234, 0, 1);
    doCycle(3'b001, 16'h0, 16'h2345, 1, 1);
    doCycle(3'b110, 16'hBEEF, 16'h5555, 0, 5);
    doCycle(3'b101, 16'h0, 16'h3456, 1, 7);
    doCycle(3'b000, 16'h0, 16'h4567, 0, 25);
  endtask

  task automatic testPassiveKind();
    tick();
    reqValid = 1; reqKind = 3'b111;
    for (int i = 0; i < 3; i++) begin
      #3;
      chk(reqAck == 0 && busStatus == 3'b111, "R2", "passive kind refused", reqAck, 0);
      tick();
    end
    reqValid = 0;
  endtask

  task automatic testSyncHeld();
    tick();
    syncRdy = 1; reqValid = 1; reqKind = 3'b100; busRdata = 16'h7777;
    tick(); reqValid = 0; reqKind = 3'b111;
    #3; chk(busStatus == 3'b100 && !done, "R3", "ready ignored in address clock", busStatus, 4);
    tick(); #3; chk(done == 0, "R4", "no done yet", done, 0);
    tick(); #3; chk(done == 1, "R4", "held ready zero waits", done, 1);
    lastRd = 16'h7777;
    syncRdy = 0;
    tick();
  endtask

  task automatic testLateAsync();
    tick();
    reqValid = 1; reqKind = 3'b101; busRdata = 16'h9999;
    tick(); reqValid = 0; reqKind = 3'b111;
    tick();
    #14 asyncRdy = 1;    // after the falling edge
    tick(); #3;
    chk(done == 0 && busStatus == 3'b101, "R5", "late async adds a wait", busStatus, 5);
    tick(); #3;
    chk(done == 1, "R5", "late async completes", done, 1);
    asyncRdy = 0;
    lastRd = 16'h9999;
    tick();
  endtask

  task automatic testLock();
    lockPrefix = 1;
    tick();
    reqValid = 1; reqKind = 3'b101; busRdata = 16'h4242;
    tick(); reqValid = 0; reqKind = 3'b111;
    #3; chk(lockN == 0, "R9", "lock with first data cycle", lockN, 0);
    syncRdy = 1;
    tick(); tick(); syncRdy = 0; lastRd = 16'h4242;
    #3; chk(lockN == 0, "R9", "lock held between cycles", lockN, 0);
    reqValid = 1; reqKind = 3'b100;
    for (int i = 0; i < 3; i++) begin
      #1; chk(reqAck == 0 && busStatus == 3'b111, "R10", "fetch refused while locked", reqAck, 0);
      tick();
    end
    reqKind = 3'b110; reqWdata = 16'hCAFE;
    #1; chk(reqAck == 1, "R10", "data cycle taken while locked", reqAck, 1);
    tick(); reqKind = 3'b100; syncRdy = 1;
    tick(); tick(); syncRdy = 0;
    #3; chk(lockN == 0 && busStatus == 3'b111, "R9", "still locked at idle", lockN, 0);
    lockPrefix = 0;
    #1; chk(reqAck == 0, "R10", "fetch refused at release edge", reqAck, 0);
    tick(); #3;
    chk(lockN == 1, "R9", "lock released", lockN, 1);
    chk(reqAck == 1, "R10", "fetch taken after release", reqAck, 1);
    tick(); reqValid = 0; reqKind = 3'b111; busRdata = 16'h6161; syncRdy = 1;
    #3; chk(busStatus == 3'b100, "R1", "fetch code", busStatus, 4);
    tick(); tick(); syncRdy = 0; lastRd = 16'h6161;
    #3; chk(rdData == 16'h6161, "R7", "fetch data", rdData, 16'h6161);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        #1 rstN = 1;
        testReset();
        testAllKinds();
        testWaits();
        testPassiveKind();
        testSyncHeld();
        testLateAsync();
        testLock();
      end
      begin
        repeat (20000) @(posedge clk);
        nRun++; nFail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule